// File: doc/BRIEF.md
# Barrel Thread Issue Scheduler

This block chooses which hardware thread of a barrel processor issues next. Each thread owns a single pending-instruction slot. A slot is busy from the cycle its thread issues until a completion pulse tagged with that thread's id returns. Completions can arrive in any order, so a short operation on one thread may retire before a long multiply started earlier on another thread. While one thread is busy, the other threads keep issuing.

Each cycle the scheduler gathers the threads that are eligible. A thread is eligible when its fetch side reports an instruction, it has no outstanding instruction-cache miss, and its slot is free or is being freed in that same cycle. Among the eligible threads it grants one in round-robin order, starting the search at a rotating pointer. The grant comes out one cycle later as a registered valid flag and thread id. Per-thread slots are tiny two-state machines: `SLOT_IDLE` and `SLOT_BUSY`. The transition *take* moves IDLE→BUSY on a grant. The transition *retire* moves BUSY→IDLE on a completion that carries no grant. A *re-take*, where a completion and a grant hit the same thread together, stays in BUSY.

The thread count is a parameter with a default of 4. Elaboration refuses a thread count smaller than the fetch depth plus one. This keeps a thread from being picked again before its instruction pointer has advanced.

Top module: `barrel_issue_sched`

## Requirements
- R1: While reset is held and on the first cycle after it, `issue_valid` is 0 and `thread_busy` is all zeros. The round-robin pointer starts at thread 0, so with every thread eligible the first grant is thread 0.
- R2: Thread i is eligible when `fetch_ready[i]`=1, `icache_miss[i]`=0, and either its slot is idle or a completion for thread i (`cmpl_valid`=1, `cmpl_tid`=i) is present in the same cycle.
- R3: The grant is the first eligible thread found when searching upward from the pointer and wrapping past NUM_THREADS-1 to 0. After a grant the pointer becomes the granted id plus one, modulo NUM_THREADS. A thread that stays eligible is never starved by lower-numbered threads.
- R4: `issue_valid` and `issue_tid` are registered. They show the grant decided from the inputs present in the cycle before the clock edge.
- R5: `thread_busy[i]` rises on the same edge on which `issue_valid`=1 with `issue_tid`=i appears. It stays 1 until a completion for thread i is accepted. A busy thread with no completion is never granted.
- R6: A completion for thread i clears only bit i of `thread_busy` on the next edge. Threads may complete in any order relative to issue.
- R7: When a completion for thread i and a new grant to thread i occur in the same cycle, thread i ends that cycle busy.
- R8: A completion naming a thread whose slot is idle has no effect: `thread_busy` and the following grants are unchanged.
- R9: A thread with `icache_miss[i]`=1 is never granted in that cycle, even when its fetch side is ready.
- R10: When no thread is eligible, `issue_valid` is 0 on the next edge and the pointer is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_ready | input | NUM_THREADS | Per thread: a fetched instruction is waiting |
| icache_miss | input | NUM_THREADS | Per thread: instruction-cache miss outstanding |
| cmpl_valid | input | 1 | A completion pulse is present this cycle |
| cmpl_tid | input | $clog2(NUM_THREADS) | Thread id of the completing instruction |
| issue_valid | output | 1 | A thread was granted (registered) |
| issue_tid | output | $clog2(NUM_THREADS) | Id of the granted thread (registered) |
| thread_busy | output | NUM_THREADS | Per-thread slot occupancy |

## Verification
A slot stuck in the wrong state appears on `thread_busy` on the very next edge. It also changes the grant sequence by the following cycle: either a thread is issued twice without completing, or a free thread is skipped. A wrong round-robin pointer shows up on the first cycle where several threads compete, as an `issue_tid` different from the wrapped upward search. The directed scenarios therefore compare all three outputs after every edge against an independent cycle model. They also force the contention patterns where each fault becomes visible: same-thread complete and reissue, completion of an idle thread, misses on low threads, and a permanently ready thread 0.

// File: rtl/sched_pkg.sv
`timescale 1ns/1ps
package sched_pkg;
    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_BUSY = 1'b1
    } slot_state_e;
endpackage

// File: rtl/thread_slot.sv
`timescale 1ns/1ps
module thread_slot
    import sched_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic done,
    output logic busy
);
    slot_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_IDLE: if (take) state_d = SLOT_BUSY;
            SLOT_BUSY: if (done && !take) state_d = SLOT_IDLE;
            default:   state_d = SLOT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_IDLE;
        else        state_q <= state_d;
    end

    assign busy = (state_q == SLOT_BUSY);

    // R2: a grant only reaches a slot that is free or being freed now
    p_take_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (!busy || done));
    // R5 / R7: a granted slot is busy on the next cycle
    p_take_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> busy);
    // R6: a completion without a grant frees the slot
    p_done_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !take) |=> !busy);
    // R8: an idle slot without a grant stays idle
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !take) |=> !busy);
endmodule

// File: rtl/rr_picker.sv
`timescale 1ns/1ps
module rr_picker #(
    parameter int NUM_THREADS = 4,
    localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_THREADS-1:0] eligible,
    output logic                   grant_any,
    output logic [TID_W-1:0]       grant_idx,
    output logic [NUM_THREADS-1:0] grant_vec
);
    logic [TID_W-1:0] ptr_q;
    logic [TID_W-1:0] ptr_d;

    // search from the pointer upward, wrapping; the nearest candidate wins
    always_comb begin
        grant_any = 1'b0;
        grant_idx = '0;
        for (int k = NUM_THREADS - 1; k >= 0; k--) begin
            int unsigned cand;
            cand = (int'(ptr_q) + k) % NUM_THREADS;
            if (eligible[cand]) begin
                grant_any = 1'b1;
                grant_idx = TID_W'(cand);
            end
        end
        grant_vec = grant_any ? (NUM_THREADS'(1) << grant_idx) : '0;
    end

    always_comb begin
        ptr_d = ptr_q;
        if (grant_any) begin
            if (int'(grant_idx) == NUM_THREADS - 1) ptr_d = '0;
            else                                    ptr_d = grant_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    // R3: at most one thread granted per cycle
    p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));
    // R2: a grant is never given to an ineligible thread
    p_grant_elig_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_any |-> ((grant_vec & ~eligible) == '0));
    // R10: the pointer holds when nothing is granted
    p_ptr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_any |=> $stable(ptr_q));
endmodule

// File: rtl/barrel_issue_sched.sv
`timescale 1ns/1ps
module barrel_issue_sched #(
    parameter int NUM_THREADS = 4,
    parameter int FETCH_DEPTH = 3,
    localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_THREADS-1:0] fetch_ready,
    input  logic [NUM_THREADS-1:0] icache_miss,
    input  logic                   cmpl_valid,
    input  logic [TID_W-1:0]       cmpl_tid,
    output logic                   issue_valid,
    output logic [TID_W-1:0]       issue_tid,
    output logic [NUM_THREADS-1:0] thread_busy
);
    // a thread must not come round again before its fetch pointer advanced
    if (NUM_THREADS < FETCH_DEPTH + 1) begin : g_bad_cfg
        $error("NUM_THREADS must be at least FETCH_DEPTH + 1");
    end

    logic [NUM_THREADS-1:0] cmpl_hit;
    logic [NUM_THREADS-1:0] eligible;
    logic [NUM_THREADS-1:0] grant_vec;
    logic                   grant_any;
    logic [TID_W-1:0]       grant_idx;
    logic                   issue_valid_q;
    logic [TID_W-1:0]       issue_tid_q;

    for (genvar i = 0; i < NUM_THREADS; i++) begin : g_slot
        assign cmpl_hit[i] = cmpl_valid && (cmpl_tid == TID_W'(i));
        assign eligible[i] = fetch_ready[i] && !icache_miss[i]
                             && (!thread_busy[i] || cmpl_hit[i]);
        thread_slot u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .take  (grant_vec[i]),
            .done  (cmpl_hit[i]),
            .busy  (thread_busy[i])
        );
    end

    rr_picker #(.NUM_THREADS(NUM_THREADS)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .eligible  (eligible),
        .grant_any (grant_any),
        .grant_idx (grant_idx),
        .grant_vec (grant_vec)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_valid_q <= 1'b0;
            issue_tid_q   <= '0;
        end else begin
            issue_valid_q <= grant_any;
            issue_tid_q   <= grant_idx;
        end
    end

    assign issue_valid = issue_valid_q;
    assign issue_tid   = issue_tid_q;

    // R5: the issued thread is reported busy alongside the issue
    p_issue_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> thread_busy[issue_tid]);
    // R9: a thread under a cache miss was not the one issued
    p_miss_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> !(($past(icache_miss) >> issue_tid) & 1));
    // R10: no ready thread in a cycle means no issue after it
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_ready == '0) |=> !issue_valid);
endmodule

// File: tb/tb_barrel_issue_sched.sv
`timescale 1ns/1ps
module tb_barrel_issue_sched;
    localparam int N  = 4;
    localparam int TW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  fetch_ready = '0;
    logic [N-1:0]  icache_miss = '0;
    logic          cmpl_valid = 1'b0;
    logic [TW-1:0] cmpl_tid = '0;
    logic          issue_valid;
    logic [TW-1:0] issue_tid;
    logic [N-1:0]  thread_busy;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [N-1:0] m_busy = '0;
    int           m_ptr = 0;
    logic         m_valid = 1'b0;
    int           m_tid = 0;

    always #5 clk = ~clk;

    barrel_issue_sched #(.NUM_THREADS(N), .FETCH_DEPTH(3)) dut (
        .clk(clk), .rst_n(rst_n), .fetch_ready(fetch_ready),
        .icache_miss(icache_miss), .cmpl_valid(cmpl_valid),
        .cmpl_tid(cmpl_tid), .issue_valid(issue_valid),
        .issue_tid(issue_tid), .thread_busy(thread_busy)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one clock: drive at the falling edge, predict, compare after the rise
    task automatic cycle(input logic [N-1:0] rdy, input logic [N-1:0] miss,
                         input logic cv, input int ct, input string req);
        logic [N-1:0] elig;
        logic         g;
        int           gi;
        @(negedge clk);
        fetch_ready = rdy;
        icache_miss = miss;
        cmpl_valid  = cv;
        cmpl_tid    = TW'(ct);
        for (int i = 0; i < N; i++)
            elig[i] = rdy[i] && !miss[i] && (!m_busy[i] || (cv && ct == i));
        g = 1'b0;
        gi = 0;
        for (int k = 0; k < N; k++) begin
            if (!g && elig[(m_ptr + k) % N]) begin
                g = 1'b1;
                gi = (m_ptr + k) % N;
            end
        end
        for (int i = 0; i < N; i++) begin
            if (g && gi == i)          m_busy[i] = 1'b1;
            else if (cv && ct == i)    m_busy[i] = 1'b0;
        end
        if (g) m_ptr = (gi + 1) % N;
        m_valid = g;
        m_tid   = gi;
        @(posedge clk);
        #1;
        chk(issue_valid == m_valid, req, "issue_valid", int'(issue_valid), int'(m_valid));
        if (m_valid)
            chk(int'(issue_tid) == m_tid, req, "issue_tid", int'(issue_tid), m_tid);
        chk(thread_busy == m_busy, req, "thread_busy", int'(thread_busy), int'(m_busy));
    endtask

    task automatic drain();
        for (int i = 0; i < N; i++)
            if (m_busy[i]) cycle('0, '0, 1'b1, i, "R6");
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        fetch_ready = '1;
        repeat (3) @(posedge clk);
        #1;
        chk(issue_valid == 1'b0, "R1", "valid in reset", int'(issue_valid), 0);
        chk(thread_busy == '0, "R1", "busy in reset", int'(thread_busy), 0);
        @(negedge clk);
        fetch_ready = '0;
        rst_n = 1'b1;
        m_busy = '0; m_ptr = 0; m_valid = 1'b0;
        @(posedge clk);
        #1;
        chk(issue_valid == 1'b0, "R1", "valid after reset", int'(issue_valid), 0);
        cycle('1, '0, 1'b0, 0, "R1");
        chk(int'(issue_tid) == 0, "R1", "first grant", int'(issue_tid), 0);
        drain();
    endtask

    // all ready, each issued thread completes in the next cycle
    task automatic t_rotation();
        int first;
        first = m_ptr;
        for (int n = 0; n < 8; n++) begin
            cycle('1, '0, m_valid, m_tid, "R3 R4 R7");
            chk(int'(issue_tid) == (first + n) % N, "R3", "rotation order",
                int'(issue_tid), (first + n) % N);
        end
        drain();
    endtask

    // thread 0 always ready and freed every cycle must not starve thread 3
    task automatic t_starve();
        int seen3 = 0;
        for (int n = 0; n < 6; n++) begin
            cycle(4'b1001, '0, m_valid, m_tid, "R3");
            if (issue_valid && issue_tid == 2'd3) seen3++;
        end
        chk(seen3 >= 2, "R3", "thread 3 grants", seen3, 2);
        drain();
    endtask

    task automatic t_busy_hold();
        cycle(4'b0010, '0, 1'b0, 0, "R5");
        for (int n = 0; n < 3; n++) cycle(4'b0010, '0, 1'b0, 0, "R5 R10");
        cycle(4'b0010, '0, 1'b1, 1, "R7");
        chk(thread_busy[1] == 1'b1, "R7", "busy after re-take", int'(thread_busy[1]), 1);
        drain();
    endtask

    task automatic t_out_of_order();
        for (int n = 0; n < 3; n++) cycle(4'b0111, '0, 1'b0, 0, "R5");
        cycle('0, '0, 1'b1, 2, "R6");
        cycle('0, '0, 1'b1, 0, "R6");
        chk(thread_busy == 4'b0010, "R6", "busy after two retires", int'(thread_busy), 2);
        cycle('0, '0, 1'b1, 1, "R6");
    endtask

    task automatic t_miss();
        for (int n = 0; n < 2; n++) cycle('1, 4'b0011, 1'b0, 0, "R9");
        drain();
        cycle('1, '1, 1'b0, 0, "R9 R10");
        cycle(4'b0001, 4'b0001, 1'b0, 0, "R9 R10");
    endtask

    task automatic t_idle_cmpl();
        cycle('0, '0, 1'b1, 2, "R8");
        chk(thread_busy == '0, "R8", "idle completion", int'(thread_busy), 0);
        cycle('1, '0, 1'b1, 3, "R8 R3");
        drain();
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_rotation();
        t_starve();
        t_busy_hold();
        t_out_of_order();
        t_miss();
        t_idle_cmpl();
        t_rotation();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule